// File: doc/BRIEF.md
# BT.656 Luma Line Capture

This block sits behind a digital video decoder and watches an 8-bit 4:2:2 component stream, one byte per accepted transfer. It recognises the embedded timing references (three fixed preamble bytes and a status byte), checks each status byte against its protection bits, and follows the field structure these references describe. From the active lines of one field it keeps only the luminance samples and writes them, one pixel per write, into an external frame buffer through a plain address/data/enable port.

A capture fills a buffer of `LINE_PIX` pixels by `FIELD_LINES` lines (640 by 244 by default). When the last line completes, the block raises `frame_ready` for one cycle and stops writing. A downstream reader then drains the buffer and pulses `read_done`; only then does the block look for the next field. The input stream uses `vid_valid` as its qualifier and has no back-pressure: every byte presented with `vid_valid` high is consumed in that cycle, and the source may leave gaps by lowering `vid_valid`. The write port also has no back-pressure; the buffer must accept one write per cycle.

Top module: `luma_line_capture`

## Requirements
- R1: After reset, `wr_en` and `frame_ready` are low, and no write occurs until a capture has been armed by a blanking reference.
- R2: A timing reference is the accepted byte run 0xFF, 0x00, 0x00, S; status byte S holds bit 7 = 1, bit 6 = F, bit 5 = V, bit 4 = H, bits 3..0 = P3..P0; H = 0 marks start of active video (SAV) and H = 1 marks end of active video (EAV).
- R3: A status byte whose bit 7 is 0 or whose protection bits differ from P3 = V^H, P2 = F^H, P1 = F^V, P0 = F^V^H is ignored: it neither starts nor ends a line.
- R4: After a SAV the samples arrive as Cb, Y, Cr, Y, ...; only the bytes in the second, fourth, sixth ... positions (Y) are written, the write appearing the cycle after the byte is accepted.
- R5: The write address of the pixel with index p on captured line n is n * LINE_PIX + p, counted from 0.
- R6: A capture is armed by any valid reference with V = 1; lines whose SAV has V = 1 or F = 1 are never captured, and capture starts at the first valid SAV with V = 0, F = 0 after arming.
- R7: Exactly FIELD_LINES lines are stored; `frame_ready` is high for one cycle, the cycle after the valid EAV ending the last line is accepted, and no write occurs from then until re-armed.
- R8: A `read_done` pulse while the buffer is held full returns the block to waiting for a V = 1 reference; `read_done` at any other time has no effect.
- R9: Bytes presented with `vid_valid` low are ignored, including for preamble detection and sample counting.
- R10: A captured line ends at its first valid EAV; at most LINE_PIX luma samples are written per line, later samples are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-side clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vid_valid | input | 1 | Qualifies `vid_data`; no back-pressure |
| vid_data | input | 8 | Interleaved 4:2:2 byte stream with embedded references |
| read_done | input | 1 | Pulse from the reader: whole buffer consumed |
| wr_en | output | 1 | Frame buffer write strobe |
| wr_addr | output | ADDR_W | Frame buffer pixel address |
| wr_data | output | 8 | Luma sample written |
| frame_ready | output | 1 | One-cycle pulse: last line stored |

## Verification
On every cycle the assertions check that write addresses stay inside the buffer, that a write only follows an accepted byte, that nothing is written while the buffer is held full, that `frame_ready` is a single-cycle pulse coinciding with entry to the hold state, and that leaving the hold state needs a `read_done`. Whether the right bytes land at the right addresses, that corrupted references, blanking lines and odd-field lines are skipped, that over-long lines are trimmed and that idle gaps do not disturb the sample order can only be shown by the bench's scenarios, which predict every write in a scoreboard and compare the pulse timing of `frame_ready` at the ports.

// File: rtl/lc_pkg.sv
package lc_pkg;

  typedef struct packed {
    logic f;
    logic v;
    logic h;
  } lc_xy_t;

  typedef enum logic [1:0] {
    ST_SYNC  = 2'd0,
    ST_ARMED = 2'd1,
    ST_LINE  = 2'd2,
    ST_HOLD  = 2'd3
  } lc_state_t;

  // Status byte: marker bit plus protection check against F, V, H.
  function automatic logic lc_xy_valid(input logic [7:0] b);
    logic f, v, h;
    f = b[6];
    v = b[5];
    h = b[4];
    return b[7] &&
           (b[3] == (v ^ h)) &&
           (b[2] == (f ^ h)) &&
           (b[1] == (f ^ v)) &&
           (b[0] == (f ^ v ^ h));
  endfunction

endpackage

// File: rtl/lc_trs_detect.sv
module lc_trs_detect
  import lc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       trs_hit,
  output lc_xy_t     xy
);

  // Number of preamble bytes matched so far (0..3).
  logic [1:0] pre_q;

  always_comb begin
    trs_hit = in_valid && (pre_q == 2'd3) && lc_xy_valid(in_data);
    xy      = '{f: in_data[6], v: in_data[5], h: in_data[4]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= 2'd0;
    end else if (in_valid) begin
      if (in_data == 8'hFF)
        pre_q <= 2'd1;
      else if (in_data == 8'h00 && pre_q == 2'd1)
        pre_q <= 2'd2;
      else if (in_data == 8'h00 && pre_q == 2'd2)
        pre_q <= 2'd3;
      else
        pre_q <= 2'd0;
    end
  end

  // R3: a reported reference always carries a well-formed status byte
  a_r3_hit_marker: assert property (@(posedge clk) disable iff (!rst_n)
    trs_hit |-> (pre_q == 2'd3) && in_data[7]);

endmodule

// File: rtl/lc_line_fsm.sv
module lc_line_fsm
  import lc_pkg::*;
#(
  parameter int LINE_PIX    = 640,
  parameter int FIELD_LINES = 244,
  parameter int ADDR_W      = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trs_hit,
  input  lc_xy_t            xy,
  input  logic              read_done,
  output logic              line_start,
  output logic              capturing,
  output logic              holding,
  output logic [ADDR_W-1:0] line_base,
  output logic              frame_ready
);

  localparam int LW = $clog2(FIELD_LINES + 1);
  localparam logic [LW-1:0]     LAST_LINE = LW'(FIELD_LINES - 1);
  localparam logic [ADDR_W-1:0] BASE_STEP = ADDR_W'(LINE_PIX);

  lc_state_t     state;
  logic [LW-1:0] line_cnt;

  always_comb begin
    line_start = trs_hit && (state == ST_ARMED) && !xy.h && !xy.v && !xy.f;
    capturing  = (state == ST_LINE);
    holding    = (state == ST_HOLD);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_SYNC;
      line_cnt    <= '0;
      line_base   <= '0;
      frame_ready <= 1'b0;
    end else begin
      frame_ready <= 1'b0;
      unique case (state)
        ST_SYNC: begin
          if (trs_hit && xy.v)
            state <= ST_ARMED;
        end
        ST_ARMED: begin
          if (line_start)
            state <= ST_LINE;
        end
        ST_LINE: begin
          if (trs_hit && xy.h) begin
            if (line_cnt == LAST_LINE) begin
              state       <= ST_HOLD;
              frame_ready <= 1'b1;
            end else begin
              state     <= ST_ARMED;
              line_cnt  <= line_cnt + 1'b1;
              line_base <= line_base + BASE_STEP;
            end
          end
        end
        ST_HOLD: begin
          if (read_done) begin
            state     <= ST_SYNC;
            line_cnt  <= '0;
            line_base <= '0;
          end
        end
        default: state <= ST_SYNC;
      endcase
    end
  end

  // R7: the completion pulse lasts one cycle
  a_r7_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ready |=> !frame_ready);

  // R7: the pulse coincides with the buffer being held
  a_r7_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ready |-> (state == ST_HOLD));

  // R8: the hold state is left only after the reader reports completion
  a_r8_leave_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_HOLD && state != ST_HOLD) |-> $past(read_done));

endmodule

// File: rtl/lc_pix_writer.sv
module lc_pix_writer #(
  parameter int LINE_PIX    = 640,
  parameter int FIELD_LINES = 244,
  parameter int ADDR_W      = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              line_start,
  input  logic              capturing,
  input  logic [ADDR_W-1:0] line_base,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);

  localparam int SAMPLES = 2 * LINE_PIX;
  localparam int SW      = $clog2(SAMPLES + 1);
  localparam int TOTAL   = LINE_PIX * FIELD_LINES;
  localparam logic [SW-1:0] SMAX = SW'(SAMPLES);

  // Position of the next byte within the active part of the line.
  logic [SW-1:0] scnt;
  logic          is_luma;

  always_comb begin
    is_luma = scnt[0] && (scnt < SMAX);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scnt    <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (line_start) begin
        scnt <= '0;
      end else if (capturing && in_valid) begin
        if (is_luma) begin
          wr_en   <= 1'b1;
          wr_addr <= line_base + ADDR_W'(scnt >> 1);
          wr_data <= in_data;
        end
        if (scnt != SMAX)
          scnt <= scnt + 1'b1;
      end
    end
  end

  // R5: every write targets a location inside the buffer
  a_r5_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_addr) < TOTAL));

  // R9: a write always stems from a byte accepted in the previous cycle
  a_r9_from_valid: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(in_valid));

endmodule

// File: rtl/luma_line_capture.sv
module luma_line_capture
  import lc_pkg::*;
#(
  parameter int LINE_PIX    = 640,
  parameter int FIELD_LINES = 244,
  parameter int ADDR_W      = $clog2(LINE_PIX * FIELD_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vid_valid,
  input  logic [7:0]        vid_data,
  input  logic              read_done,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              frame_ready
);

  logic              trs_hit;
  lc_xy_t            xy;
  logic              line_start;
  logic              capturing;
  logic              holding;
  logic [ADDR_W-1:0] line_base;

  lc_trs_detect i_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (vid_valid),
    .in_data  (vid_data),
    .trs_hit  (trs_hit),
    .xy       (xy)
  );

  lc_line_fsm #(
    .LINE_PIX    (LINE_PIX),
    .FIELD_LINES (FIELD_LINES),
    .ADDR_W      (ADDR_W)
  ) i_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .trs_hit     (trs_hit),
    .xy          (xy),
    .read_done   (read_done),
    .line_start  (line_start),
    .capturing   (capturing),
    .holding     (holding),
    .line_base   (line_base),
    .frame_ready (frame_ready)
  );

  lc_pix_writer #(
    .LINE_PIX    (LINE_PIX),
    .FIELD_LINES (FIELD_LINES),
    .ADDR_W      (ADDR_W)
  ) i_writer (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (vid_valid),
    .in_data    (vid_data),
    .line_start (line_start),
    .capturing  (capturing),
    .line_base  (line_base),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data)
  );

  // R7: no write lands while the full buffer waits for the reader
  a_r7_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (holding && $past(holding)) |-> !wr_en);

endmodule

// File: tb/test_luma_line_capture.sv
`timescale 1ns/1ps
module test_luma_line_capture;

  localparam int LP     = 16;
  localparam int FL     = 4;
  localparam int ADDR_W = $clog2(LP * FL);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              vid_valid = 1'b0;
  logic [7:0]        vid_data = 8'hFF;
  logic              read_done = 1'b0;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;
  logic              frame_ready;

  always #4 clk = ~clk;

  luma_line_capture #(.LINE_PIX(LP), .FIELD_LINES(FL)) i_luma_line_capture (
    .clk(clk), .rst_n(rst_n), .vid_valid(vid_valid), .vid_data(vid_data),
    .read_done(read_done), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .frame_ready(frame_ready)
  );

  int checks = 0;
  int fails  = 0;
  int nwr    = 0;
  int nready = 0;
  int exp_addr[$];
  int exp_data[$];

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: each observed write is matched against the queue.
  always @(negedge clk) begin
    if (rst_n && frame_ready) nready++;
    if (rst_n && wr_en) begin
      nwr++;
      if (exp_addr.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL R6/R7 unexpected write: actual addr %0d data %0d expected none",
                 wr_addr, wr_data);
      end else begin
        int ea, ed;
        ea = exp_addr.pop_front();
        ed = exp_data.pop_front();
        check_eq("R5 write address", int'(wr_addr), ea);
        check_eq("R4 luma data", int'(wr_data), ed);
      end
    end
  end

  function automatic logic [7:0] ydat(input int seed, input int line, input int pix);
    return 8'(32 + ((seed * 31 + line * 13 + pix * 5) % 200));
  endfunction

  function automatic logic [7:0] mk_xy(input bit f, input bit v, input bit h, input bit bad);
    logic [7:0] b;
    b = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    return bad ? (b ^ 8'h01) : b;
  endfunction

  task automatic put_byte(input logic [7:0] b);
    @(negedge clk);
    vid_valid = 1'b1;
    vid_data  = b;
  endtask

  task automatic idle_byte();
    @(negedge clk);
    vid_valid = 1'b0;
    vid_data  = 8'hFF;   // garbage while not valid (R9)
  endtask

  task automatic send_trs(input bit f, input bit v, input bit h, input bit bad);
    put_byte(8'hFF);
    put_byte(8'h00);
    put_byte(8'h00);
    put_byte(mk_xy(f, v, h, bad));
  endtask

  // One line: SAV, samples, EAV. When expect_it is set, the Y samples are
  // queued for buffer line exp_line.
  task automatic send_line(input bit f, input bit v, input bit bad_sav,
                           input int nsamp, input int seed, input int gaps,
                           input bit expect_it, input int exp_line);
    send_trs(f, v, 1'b0, bad_sav);
    for (int i = 0; i < nsamp; i++) begin
      logic [7:0] b;
      if (gaps != 0 && (i % gaps) == gaps - 1) idle_byte();
      b = (i % 2 == 1) ? ydat(seed, exp_line, i / 2) : 8'h80;
      if (expect_it && (i % 2 == 1) && (i / 2) < LP) begin
        exp_addr.push_back(exp_line * LP + i / 2);
        exp_data.push_back(int'(b));
      end
      put_byte(b);
    end
    send_trs(f, v, 1'b1, 1'b0);
    idle_byte();
  endtask

  task automatic pulse_read_done();
    @(negedge clk);
    read_done = 1'b1;
    @(negedge clk);
    read_done = 1'b0;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int w0;
    repeat (5) @(negedge clk);
    check_eq("R1 wr_en in reset", int'(wr_en), 0);
    check_eq("R1 frame_ready in reset", int'(frame_ready), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_eq("R1 wr_en after reset", int'(wr_en), 0);

    // Active line before any blanking reference: not armed yet.
    w0 = nwr;
    send_line(1'b0, 1'b0, 1'b0, 2 * LP, 1, 0, 1'b0, 0);
    check_eq("R1 no write before arming", nwr - w0, 0);

    // Two blanking lines arm the capture but are not stored.
    w0 = nwr;
    send_line(1'b0, 1'b1, 1'b0, 2 * LP, 2, 0, 1'b0, 0);
    send_line(1'b0, 1'b1, 1'b0, 2 * LP, 2, 0, 1'b0, 0);
    check_eq("R6 blanking lines not stored", nwr - w0, 0);

    // Buffer line 0.
    w0 = nwr;
    send_line(1'b0, 1'b0, 1'b0, 2 * LP, 3, 0, 1'b1, 0);
    check_eq("R2 first active line stored", nwr - w0, LP);

    // read_done while capturing must be ignored.
    pulse_read_done();

    // Odd-field line and a line with a corrupted SAV are skipped.
    w0 = nwr;
    send_line(1'b1, 1'b0, 1'b0, 2 * LP, 4, 0, 1'b0, 0);
    check_eq("R6 F=1 line skipped", nwr - w0, 0);
    w0 = nwr;
    send_line(1'b0, 1'b0, 1'b1, 2 * LP, 5, 0, 1'b0, 0);
    check_eq("R3 bad SAV ignored", nwr - w0, 0);

    // Buffer line 1: over-long line, trimmed to LP pixels.
    w0 = nwr;
    send_line(1'b0, 1'b0, 1'b0, 2 * LP + 10, 6, 0, 1'b1, 1);
    check_eq("R10 long line trimmed", nwr - w0, LP);

    // Blanking mid-field is not stored.
    w0 = nwr;
    send_line(1'b0, 1'b1, 1'b0, 2 * LP, 7, 0, 1'b0, 0);
    check_eq("R6 mid-field blanking skipped", nwr - w0, 0);

    // Buffer line 2 with idle gaps in the stream.
    w0 = nwr;
    send_line(1'b0, 1'b0, 1'b0, 2 * LP, 8, 3, 1'b1, 2);
    check_eq("R9 gapped line stored", nwr - w0, LP);
    check_eq("R8 read_done during capture ignored", nready, 0);

    // Buffer line 3: last; check frame_ready timing by hand.
    send_trs(1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 2 * LP; i++) begin
      logic [7:0] b;
      b = (i % 2 == 1) ? ydat(9, 3, i / 2) : 8'h80;
      if (i % 2 == 1) begin
        exp_addr.push_back(3 * LP + i / 2);
        exp_data.push_back(int'(b));
      end
      put_byte(b);
    end
    send_trs(1'b0, 1'b0, 1'b1, 1'b0);
    idle_byte();
    check_eq("R7 frame_ready after last EAV", int'(frame_ready), 1);
    idle_byte();
    check_eq("R7 frame_ready one cycle", int'(frame_ready), 0);
    check_eq("R5 all queued writes seen", exp_addr.size(), 0);

    // Held: a whole new field produces no writes.
    w0 = nwr;
    send_line(1'b0, 1'b1, 1'b0, 2 * LP, 10, 0, 1'b0, 0);
    for (int n = 0; n < FL; n++)
      send_line(1'b0, 1'b0, 1'b0, 2 * LP, 10, 0, 1'b0, 0);
    check_eq("R7 no writes while held", nwr - w0, 0);
    check_eq("R7 single completion pulse", nready, 1);

    // Re-arm and capture a second field from address 0.
    pulse_read_done();
    send_line(1'b0, 1'b1, 1'b0, 2 * LP, 11, 0, 1'b0, 0);
    w0 = nwr;
    for (int n = 0; n < FL; n++)
      send_line(1'b0, 1'b0, 1'b0, 2 * LP, 12, 5, 1'b1, n);
    repeat (3) @(negedge clk);
    check_eq("R8 second field stored after re-arm", nwr - w0, FL * LP);
    check_eq("R8 second completion pulse", nready, 2);
    check_eq("R5 scoreboard drained", exp_addr.size(), 0);

    finish_run();
  end

endmodule